// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Request Front End

This block combines two eight-line interrupt controllers, a primary and a secondary, into a single sixteen-line request front end. Device interrupt sources use raise and lower strobes that carry a line number. The block keeps a request register and an in-service register for each chip. It applies the per-chip mask inputs and presents the winning vector, formed from that chip's base vector. The command units drive the masks and base vectors into the block as plain inputs.

The processor side acknowledges a vector. The block maps the vector back to a line and moves that request into service. End-of-interrupt commands clear in-service bits. If an unmasked request is still waiting after an end-of-interrupt, the block raises a warning. Each chip also has a byte-wide trigger-mode register behind a small select/write/read port, and each of these registers keeps only the bits its fixed writable mask allows.

Top module: `pic_cascade_front`

## Requirements
- R1: A raise on line 2 is applied as a raise on line 9, which sets secondary request bit 1. It also sets primary request bit 2, the cascade input.
- R2: A raise on lines 0 to 7 sets primary request bit n. A raise on lines 8 to 15 sets secondary request bit n-8. The new bit is visible one clock after the strobe.
- R3: A raise with a line number of 16 or more changes no request bit. It pulses `line_err` high for the one cycle after the strobe.
- R4: A lower on lines 0 to 7 clears primary request bit n. A lower on lines 8 to 15 clears secondary request bit n-8. Lower on line 2 clears only primary bit 2.
- R5: The winner is the lowest-numbered line, scanning 0 to 15 across both chips, whose request bit is set and whose mask bit is clear. In-service bits play no part in the scan.
- R6: For a winning line n below 8, `irq_vector` is primary base + n. Otherwise it is secondary base + (n-8), modulo 2^VEC_W. `irq_pending` is high while a winner exists.
- R7: With no unmasked request, `irq_pending` is low and `irq_vector` is zero.
- R8: An acknowledge whose vector minus the primary base, taken modulo 2^VEC_W, is below 8 sets primary in-service bit (vector & 7) and clears the matching primary request bit. If that test fails and the same test against the secondary base passes, the secondary chip is updated the same way. A vector that passes neither test changes nothing.
- R9: A specific end-of-interrupt clears the in-service bit given by `eoi_level` in the chip chosen by `eoi_slave` (1 = secondary). A non-specific one clears the lowest-numbered set in-service bit of that chip.
- R10: In the cycle after an end-of-interrupt strobe, `eoi_warn` is high exactly when an unmasked request is pending in the updated state.
- R11: A write to a trigger-mode register stores the write data ANDed with that chip's mask: 8'hF8 for the primary (`elc_sel`=0) and 8'hDE for the secondary (`elc_sel`=1). `elc_rdata` returns the stored value of the selected chip.
- R12: Reset clears both request registers, both in-service registers and both trigger-mode registers.
- R13: When events coincide in one cycle, a raise wins over a lower or an acknowledge on the same request bit. An acknowledge setting an in-service bit wins over an end-of-interrupt clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_stb | input | 1 | Raise strobe for `line_id` |
| lower_stb | input | 1 | Lower strobe for `line_id` |
| line_id | input | LINE_W | Line number for raise/lower |
| mst_mask | input | 8 | Primary mask, 1 = masked |
| slv_mask | input | 8 | Secondary mask, 1 = masked |
| mst_base | input | VEC_W | Primary base vector |
| slv_base | input | VEC_W | Secondary base vector |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_vec | input | VEC_W | Acknowledged vector |
| eoi_stb | input | 1 | End-of-interrupt strobe |
| eoi_slave | input | 1 | Target chip: 0 primary, 1 secondary |
| eoi_specific | input | 1 | 1 = clear `eoi_level`, 0 = clear lowest set bit |
| eoi_level | input | 3 | In-service bit for a specific EOI |
| elc_sel | input | 1 | Trigger-mode register select |
| elc_we | input | 1 | Trigger-mode register write enable |
| elc_wdata | input | 8 | Trigger-mode write data |
| elc_rdata | output | 8 | Selected trigger-mode register |
| irq_pending | output | 1 | An unmasked request exists |
| irq_vector | output | VEC_W | Winning vector, zero when none |
| line_err | output | 1 | Out-of-range raise seen last cycle |
| eoi_warn | output | 1 | Request still pending after EOI |
| mst_req | output | 8 | Primary request register |
| slv_req | output | 8 | Secondary request register |
| mst_isr | output | 8 | Primary in-service register |
| slv_isr | output | 8 | Secondary in-service register |

## Verification
The bench uses the default parameters. LINE_W=5 makes line numbers 16 to 31 reachable, so the rejection path is exercised. The default trigger-mode masks leave read-only bits in both chips, so writes of all ones show the masking. Base vectors are moved between aligned values so that acknowledges land inside either chip's window or outside both. Masks are re-randomized during the run so the scan sees both masked and unmasked winners.

// File: rtl/pic_cf_pkg.sv
package pic_cf_pkg;
   localparam int unsigned CHIP_LINES = 8;
   localparam int unsigned NUM_CHIPS  = 2;
   localparam int unsigned NUM_LINES  = CHIP_LINES * NUM_CHIPS;
   localparam int unsigned CHIP_IW    = $clog2(CHIP_LINES);
   localparam int unsigned LINE_IW    = $clog2(NUM_LINES);

   typedef logic [CHIP_LINES-1:0] chip_vec_t;
   typedef logic [NUM_LINES-1:0]  line_vec_t;
endpackage

// File: rtl/pic_cf_bank.sv
module pic_cf_bank
   import pic_cf_pkg::*;
#(
   parameter int unsigned LINES = CHIP_LINES,
   localparam int unsigned IW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] set_bits,
   input  logic [LINES-1:0] clr_bits,
   input  logic             ack_hit,
   input  logic [IW-1:0]    ack_idx,
   input  logic             eoi_hit,
   input  logic             eoi_specific,
   input  logic [IW-1:0]    eoi_idx,
   output logic [LINES-1:0] req_q,
   output logic [LINES-1:0] isr_q
);

   logic [LINES-1:0] ack_oh;
   logic [LINES-1:0] low_oh;
   logic [LINES-1:0] eoi_oh;

   always_comb begin
      low_oh = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (isr_q[i]) low_oh = LINES'(1) << i;
      end
   end

   always_comb begin
      ack_oh = ack_hit ? (LINES'(1) << ack_idx) : '0;
      if (!eoi_hit)         eoi_oh = '0;
      else if (eoi_specific) eoi_oh = LINES'(1) << eoi_idx;
      else                  eoi_oh = low_oh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
         isr_q <= '0;
      end else begin
         req_q <= (req_q & ~clr_bits & ~ack_oh) | set_bits;
         isr_q <= (isr_q & ~eoi_oh) | ack_oh;
      end
   end

   AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit |=> isr_q[$past(ack_idx)]);  // R8

   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && eoi_specific && !ack_hit) |=> !isr_q[$past(eoi_idx)]);  // R9

   AST_RAISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((req_q & $past(set_bits)) == $past(set_bits)));  // R13

endmodule

// File: rtl/pic_cf_scan.sv
module pic_cf_scan
   import pic_cf_pkg::*;
#(
   parameter int unsigned VEC_W = 8,
   localparam int unsigned TOTAL = NUM_LINES
) (
   input  chip_vec_t        m_req,
   input  chip_vec_t        m_mask,
   input  chip_vec_t        s_req,
   input  chip_vec_t        s_mask,
   input  logic [VEC_W-1:0] m_base,
   input  logic [VEC_W-1:0] s_base,
   output logic             hit,
   output logic [VEC_W-1:0] vector
);

   line_vec_t            pend;
   logic [LINE_IW-1:0]   sel;
   logic [VEC_W-1:0]     off;

   assign pend = {s_req & ~s_mask, m_req & ~m_mask};

   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int i = TOTAL - 1; i >= 0; i--) begin
         if (pend[i]) begin
            hit = 1'b1;
            sel = LINE_IW'(i);
         end
      end
   end

   assign off = VEC_W'(sel[CHIP_IW-1:0]);

   always_comb begin
      if (!hit)                vector = '0;
      else if (sel[CHIP_IW])   vector = s_base + off;
      else                     vector = m_base + off;
   end

endmodule

// File: rtl/pic_cf_elc.sv
module pic_cf_elc #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] WMASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & WMASK;
   end

endmodule

// File: rtl/pic_cascade_front.sv
module pic_cascade_front
   import pic_cf_pkg::*;
#(
   parameter int unsigned LINE_W        = 5,
   parameter int unsigned VEC_W         = 8,
   parameter logic [7:0]  MST_ELC_MASK  = 8'hF8,
   parameter logic [7:0]  SLV_ELC_MASK  = 8'hDE,
   parameter int unsigned CASCADE_LINE  = 2,
   parameter int unsigned REDIRECT_LINE = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raise_stb,
   input  logic              lower_stb,
   input  logic [LINE_W-1:0] line_id,
   input  logic [7:0]        mst_mask,
   input  logic [7:0]        slv_mask,
   input  logic [VEC_W-1:0]  mst_base,
   input  logic [VEC_W-1:0]  slv_base,
   input  logic              ack_stb,
   input  logic [VEC_W-1:0]  ack_vec,
   input  logic              eoi_stb,
   input  logic              eoi_slave,
   input  logic              eoi_specific,
   input  logic [2:0]        eoi_level,
   input  logic              elc_sel,
   input  logic              elc_we,
   input  logic [7:0]        elc_wdata,
   output logic [7:0]        elc_rdata,
   output logic              irq_pending,
   output logic [VEC_W-1:0]  irq_vector,
   output logic              line_err,
   output logic              eoi_warn,
   output logic [7:0]        mst_req,
   output logic [7:0]        slv_req,
   output logic [7:0]        mst_isr,
   output logic [7:0]        slv_isr
);

   localparam logic [7:0] ELC_MASKS [NUM_CHIPS] = '{MST_ELC_MASK, SLV_ELC_MASK};

   if (LINE_W < LINE_IW) begin : g_bad_line_w
      $error("pic_cascade_front: LINE_W too small for sixteen lines");
   end
   if (VEC_W < CHIP_IW) begin : g_bad_vec_w
      $error("pic_cascade_front: VEC_W too small");
   end
   if (CASCADE_LINE >= CHIP_LINES || REDIRECT_LINE < CHIP_LINES || REDIRECT_LINE >= NUM_LINES) begin : g_bad_cascade
      $error("pic_cascade_front: cascade lines out of range");
   end

   // line decode
   logic              in_range;
   logic              is_cascade;
   logic [LINE_IW-1:0] eff_line;
   line_vec_t         raise_set;
   line_vec_t         lower_clr;

   if (LINE_W > LINE_IW) begin : g_range_chk
      assign in_range = (line_id[LINE_W-1:LINE_IW] == '0);
   end else begin : g_range_all
      assign in_range = 1'b1;
   end

   assign is_cascade = in_range && (line_id[LINE_IW-1:0] == LINE_IW'(CASCADE_LINE));
   assign eff_line   = is_cascade ? LINE_IW'(REDIRECT_LINE) : line_id[LINE_IW-1:0];

   always_comb begin
      raise_set = '0;
      if (raise_stb && in_range) begin
         raise_set = NUM_LINES'(1) << eff_line;
         if (is_cascade) raise_set[CASCADE_LINE] = 1'b1;
      end
      lower_clr = (lower_stb && in_range) ? (NUM_LINES'(1) << line_id[LINE_IW-1:0]) : '0;
   end

   // acknowledge window decode
   logic [VEC_W-1:0] m_off;
   logic [VEC_W-1:0] s_off;
   logic [NUM_CHIPS-1:0] ack_hit;

   assign m_off      = ack_vec - mst_base;
   assign s_off      = ack_vec - slv_base;
   assign ack_hit[0] = ack_stb && (m_off < VEC_W'(CHIP_LINES));
   assign ack_hit[1] = ack_stb && !ack_hit[0] && (s_off < VEC_W'(CHIP_LINES));

   // per-chip banks and trigger-mode registers
   chip_vec_t req_arr [NUM_CHIPS];
   chip_vec_t isr_arr [NUM_CHIPS];
   chip_vec_t elc_arr [NUM_CHIPS];

   for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
      pic_cf_bank #(.LINES(CHIP_LINES)) i_bank (
         .clk          (clk),
         .rst_n        (rst_n),
         .set_bits     (raise_set[g*CHIP_LINES +: CHIP_LINES]),
         .clr_bits     (lower_clr[g*CHIP_LINES +: CHIP_LINES]),
         .ack_hit      (ack_hit[g]),
         .ack_idx      (ack_vec[CHIP_IW-1:0]),
         .eoi_hit      (eoi_stb && (eoi_slave == 1'(g))),
         .eoi_specific (eoi_specific),
         .eoi_idx      (eoi_level),
         .req_q        (req_arr[g]),
         .isr_q        (isr_arr[g])
      );

      pic_cf_elc #(.W(CHIP_LINES), .WMASK(ELC_MASKS[g])) i_elc (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (elc_we && (elc_sel == 1'(g))),
         .wdata (elc_wdata),
         .q     (elc_arr[g])
      );
   end

   assign mst_req   = req_arr[0];
   assign slv_req   = req_arr[1];
   assign mst_isr   = isr_arr[0];
   assign slv_isr   = isr_arr[1];
   assign elc_rdata = elc_arr[elc_sel];

   pic_cf_scan #(.VEC_W(VEC_W)) i_scan (
      .m_req  (req_arr[0]),
      .m_mask (mst_mask),
      .s_req  (req_arr[1]),
      .s_mask (slv_mask),
      .m_base (mst_base),
      .s_base (slv_base),
      .hit    (irq_pending),
      .vector (irq_vector)
   );

   // status pulses
   logic eoi_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_err <= 1'b0;
         eoi_seen <= 1'b0;
      end else begin
         line_err <= raise_stb && !in_range;
         eoi_seen <= eoi_stb;
      end
   end

   assign eoi_warn = eoi_seen && irq_pending;

   // assertions
   line_vec_t all_req;
   assign all_req = {slv_req, mst_req};

   AST_CASCADE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_stb && is_cascade) |=> (mst_req[CASCADE_LINE] && all_req[REDIRECT_LINE]));  // R1

   AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_stb && in_range) |=> all_req[$past(eff_line)]);  // R2

   AST_BAD_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_stb && !in_range && !lower_stb && !ack_stb) |=>
         (line_err && $stable(mst_req) && $stable(slv_req)));  // R3

   AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lower_stb && !raise_stb && in_range) |=> !all_req[$past(line_id[LINE_IW-1:0])]);  // R4

   AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (((mst_req & ~mst_mask) == '0) && ((slv_req & ~slv_mask) == '0)) |->
         (!irq_pending && (irq_vector == '0)));  // R7

   AST_EOI_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(eoi_stb) && irq_pending) |-> eoi_warn);  // R10

   AST_ELC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (elc_we && !elc_sel) |=> (elc_arr[0] == ($past(elc_wdata) & MST_ELC_MASK)));  // R11

endmodule

// File: tb/test_pic_cascade_front.sv
module test_pic_cascade_front;
   localparam int CLK_P = 10;
   localparam logic [7:0] MM = 8'hF8;
   localparam logic [7:0] SM = 8'hDE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic       raise_stb = 0, lower_stb = 0, ack_stb = 0, eoi_stb = 0;
   logic       eoi_slave = 0, eoi_specific = 0, elc_sel = 0, elc_we = 0;
   logic [4:0] line_id = 0;
   logic [7:0] mst_mask = 0, slv_mask = 0, mst_base = 8'h20, slv_base = 8'h28;
   logic [7:0] ack_vec = 0, elc_wdata = 0;
   logic [2:0] eoi_level = 0;
   logic [7:0] elc_rdata, irq_vector, mst_req, slv_req, mst_isr, slv_isr;
   logic       irq_pending, line_err, eoi_warn;

   pic_cascade_front i_pic_cascade_front (
      .clk(clk), .rst_n(rst_n), .raise_stb(raise_stb), .lower_stb(lower_stb),
      .line_id(line_id), .mst_mask(mst_mask), .slv_mask(slv_mask),
      .mst_base(mst_base), .slv_base(slv_base), .ack_stb(ack_stb), .ack_vec(ack_vec),
      .eoi_stb(eoi_stb), .eoi_slave(eoi_slave), .eoi_specific(eoi_specific),
      .eoi_level(eoi_level), .elc_sel(elc_sel), .elc_we(elc_we), .elc_wdata(elc_wdata),
      .elc_rdata(elc_rdata), .irq_pending(irq_pending), .irq_vector(irq_vector),
      .line_err(line_err), .eoi_warn(eoi_warn), .mst_req(mst_req), .slv_req(slv_req),
      .mst_isr(mst_isr), .slv_isr(slv_isr)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] m_req = 0, s_req = 0, m_isr = 0, s_isr = 0, m_elc = 0, s_elc = 0;
   logic       x_err = 0, x_warn = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [8:0] pick(input logic [7:0] mr, sr, mm, sm, mb, sb);
      logic [15:0] p = {sr & ~sm, mr & ~mm};
      for (int i = 0; i < 16; i++)
         if (p[i]) return {1'b1, (i < 8) ? mb + 8'(i) : sb + 8'(i - 8)};
      return 9'd0;
   endfunction

   function automatic logic [7:0] lowest(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return 8'(1) << i;
      return 8'd0;
   endfunction

   task automatic model_update();
      logic [15:0] set16 = 0, clr16 = 0;
      logic [7:0]  am = 0, as = 0, e_oh = 0, mo, so;
      if (raise_stb && line_id < 16) begin
         set16 = 16'(1) << ((line_id == 2) ? 5'd9 : line_id);
         if (line_id == 2) set16[2] = 1'b1;
      end
      if (lower_stb && line_id < 16) clr16 = 16'(1) << line_id;
      mo = ack_vec - mst_base;
      so = ack_vec - slv_base;
      if (ack_stb) begin
         if (mo < 8)      am = 8'(1) << ack_vec[2:0];
         else if (so < 8) as = 8'(1) << ack_vec[2:0];
      end
      if (eoi_stb) e_oh = eoi_specific ? (8'(1) << eoi_level) : lowest(eoi_slave ? s_isr : m_isr);
      m_req = (m_req & ~clr16[7:0] & ~am) | set16[7:0];
      s_req = (s_req & ~clr16[15:8] & ~as) | set16[15:8];
      m_isr = (m_isr & ~(eoi_slave ? 8'd0 : e_oh)) | am;
      s_isr = (s_isr & ~(eoi_slave ? e_oh : 8'd0)) | as;
      if (elc_we) begin
         if (elc_sel) s_elc = elc_wdata & SM;
         else         m_elc = elc_wdata & MM;
      end
      x_err  = raise_stb && line_id >= 16;
      x_warn = eoi_stb && pick(m_req, s_req, mst_mask, slv_mask, mst_base, slv_base)[8];
   endtask

   // drive at negedge, model at the edge, compare at the following negedge
   task automatic step(input logic r, l, input logic [4:0] ln, input logic a,
                       input logic [7:0] av, input logic e, es, esp, input logic [2:0] el,
                       input logic w, sel, input logic [7:0] wd);
      logic [8:0] pv;
      raise_stb = r; lower_stb = l; line_id = ln; ack_stb = a; ack_vec = av;
      eoi_stb = e; eoi_slave = es; eoi_specific = esp; eoi_level = el;
      elc_we = w; elc_sel = sel; elc_wdata = wd;
      @(posedge clk);
      model_update();
      @(negedge clk);
      pv = pick(m_req, s_req, mst_mask, slv_mask, mst_base, slv_base);
      chk("R2 primary request", 32'(mst_req), 32'(m_req));
      chk("R2 secondary request", 32'(slv_req), 32'(s_req));
      chk("R8 primary in-service", 32'(mst_isr), 32'(m_isr));
      chk("R9 secondary in-service", 32'(slv_isr), 32'(s_isr));
      chk("R5 pending/vector", 32'({irq_pending, irq_vector}), 32'(pv));
      chk("R3 line error", 32'(line_err), 32'(x_err));
      chk("R10 eoi warning", 32'(eoi_warn), 32'(x_warn));
      chk("R11 trigger-mode read", 32'(elc_rdata), 32'(sel ? s_elc : m_elc));
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, elc_sel, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 reset requests", 32'({mst_req, slv_req}), 32'd0);
      chk("R12 reset in-service", 32'({mst_isr, slv_isr}), 32'd0);
      chk("R12 reset trigger mode", 32'(elc_rdata), 32'd0);
      chk("R7 idle pending", 32'({irq_pending, irq_vector}), 32'd0);

      // R1 cascade redirect; scan picks primary bit 2 first
      step(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 cascade bits", 32'({mst_req, slv_req}), 32'h0402);
      chk("R6 vector of line 2", 32'(irq_vector), 32'h22);
      // R7 all masked
      mst_mask = 8'hFF; slv_mask = 8'hFF;
      idle();
      chk("R7 masked idle", 32'({irq_pending, irq_vector}), 32'd0);
      // R5 secondary winner when primary masked
      mst_mask = 8'hFF; slv_mask = 8'h00;
      idle();
      chk("R5 secondary winner", 32'(irq_vector), 32'h29);
      mst_mask = 8'h00;
      // R4 lower line 2 leaves bit 9
      step(0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R4 lower line 2", 32'({mst_req, slv_req}), 32'h0002);
      // R3 out-of-range raise
      step(1, 0, 20, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R3 rejected line", 32'({line_err, mst_req, slv_req}), 32'h10002);
      // R6 line 12
      step(1, 0, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R6 line 12 vector", 32'(irq_vector), 32'h2C);
      // R8 acknowledge outside both windows ignored, then inside secondary
      step(0, 0, 0, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
      chk("R8 ignored ack", 32'({mst_isr, slv_isr, slv_req}), 32'h000010);
      step(0, 0, 0, 1, 8'h2C, 0, 0, 0, 0, 0, 0, 0);
      chk("R8 accepted ack", 32'({slv_isr, slv_req}), 32'h1000);
      // R9 non-specific EOI clears lowest set bit
      step(0, 0, 0, 1, 8'h29, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
      chk("R9 non-specific", 32'(slv_isr), 32'h10);
      // R10 warning with request still pending
      step(1, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 1, 1, 3'd4, 0, 0, 0);
      chk("R10 warn raised", 32'({eoi_warn, slv_isr}), 32'h100);
      idle();
      chk("R10 warn one cycle", 32'(eoi_warn), 32'd0);
      // R13 raise beats lower and ack on line 5; ack beats eoi
      step(1, 1, 5, 1, 8'h25, 1, 0, 1, 3'd5, 0, 0, 0);
      chk("R13 coincident", 32'({mst_req[5], mst_isr[5]}), 32'h3);
      // R11 trigger-mode masks
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 8'hFF);
      chk("R11 primary mask", 32'(elc_rdata), 32'hF8);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8'hFF);
      chk("R11 secondary mask", 32'(elc_rdata), 32'hDE);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [4:0] ln;
         logic [7:0] av;
         if ($urandom_range(0, 49) == 0) begin
            mst_mask = 8'($urandom); slv_mask = 8'($urandom);
         end
         if ($urandom_range(0, 199) == 0) begin
            mst_base = 8'($urandom_range(0, 31)) << 3;
            slv_base = 8'($urandom_range(0, 31)) << 3;
         end
         ln = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(16, 31)) : 5'($urandom_range(0, 15));
         case ($urandom_range(0, 2))
            0: av = mst_base + 8'($urandom_range(0, 7));
            1: av = slv_base + 8'($urandom_range(0, 7));
            default: av = 8'($urandom);
         endcase
         step($urandom_range(0, 9) < 4, $urandom_range(0, 9) < 2, ln,
              $urandom_range(0, 3) == 0, av, $urandom_range(0, 6) == 0,
              1'($urandom), 1'($urandom), 3'($urandom),
              $urandom_range(0, 9) == 0, 1'($urandom), 8'($urandom));
      end
      idle();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule